// File: doc/BRIEF.md
# Programmable Autowake Sleep Timer

This block wakes a chip from a low-power state after a programmed delay. It runs on a slow crystal-rate clock. Firmware writes a 3-bit period and a 1-bit resolution select into two configuration registers. It then arms the timer with a write strobe, which captures both values. When the sleep command strobe arrives, the timer counts down the captured period times the selected time unit and raises a one-cycle wake pulse.

The timer keeps its armed state while the chip is still in its normal operating mode, because that is where firmware arms it. A countdown in progress is cancelled when the power mode returns to normal operation or drops to brownout. Brownout also clears an armed timer. The sleep command must come at least a guard number of clock edges after arming. A command that comes too early sets a sticky late-arm error and does not start the countdown.

Top module: `slp_wake_timer`

## Requirements
- R1: `cfg_wr` loads `cfg_prd_i` (3 bits) and `cfg_res_i` into the configuration registers read back on `cfg_prd_o`/`cfg_res_o`. Reset sets the period to 1 and the resolution to 0. Without `cfg_wr` the registers hold.
- R2: Arming captures the configuration register values present in that cycle. Writes made after arming do not change the interval of that armed timer.
- R3: The time unit is `SHORT_UNIT` cycles when resolution is 0 and `LONG_UNIT` cycles when it is 1. `wake_o` rises on the (period×unit + 1)th clock edge after the edge that accepts the sleep command. A period of 0 therefore wakes on the first edge.
- R4: `wake_o` is high for exactly one cycle. In that cycle `armed_o` is already low.
- R5: `armed_o` is high from the arming edge until wake, cancellation or a late-arm error. It stays high through the countdown.
- R6: Power mode encoding: 0 = normal, 1 = brownout, 2 = sleep, 3 = display-only. Normal or brownout during a countdown cancels it and gives no wake. Brownout also clears an armed timer, and `arm_wr` has no effect during brownout.
- R7: A `sleep_cmd` is accepted only when it comes at least `GUARD_CYC` (3) edges after the arming edge. An earlier one, or one in the same cycle as `arm_wr`, sets `late_err_o`, disarms the timer and starts no countdown.
- R8: `late_err_o` is sticky. Only reset clears it.
- R9: `sleep_cmd` has no effect while the timer is disarmed or already counting.
- R10: The countdown runs in both sleep mode (2) and display-only mode (3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Write strobe for period and resolution registers |
| cfg_prd_i | input | 3 | Period value to write |
| cfg_res_i | input | 1 | Resolution select to write (1 = long unit) |
| arm_wr | input | 1 | Arm strobe; captures current configuration |
| pwr_mode | input | 2 | Current power mode (0 normal, 1 brownout, 2 sleep, 3 display-only) |
| sleep_cmd | input | 1 | Sleep command strobe that starts the countdown |
| cfg_prd_o | output | 3 | Period register readback |
| cfg_res_o | output | 1 | Resolution register readback |
| wake_o | output | 1 | One-cycle wake pulse at terminal count |
| armed_o | output | 1 | Timer armed or counting |
| late_err_o | output | 1 | Sticky late-arm error |

## Verification
The bench builds the timer with `SHORT_UNIT` = 3 and `LONG_UNIT` = 7 in place of the crystal-rate counts. With these values every period from 0 to 7 under both resolutions finishes within about fifty cycles, so the full 16-point sweep of intervals runs and each one is compared with period×unit + 1. The small units also let the bench cancel a countdown partway through and confirm that no wake follows. The guard window keeps its real value of 3, so every gap from 0 to 3 edges between arming and the sleep command is tried.

// File: rtl/swt_pkg.sv
package swt_pkg;

   typedef enum logic [1:0] {
      PM_NORMAL   = 2'd0,
      PM_BROWNOUT = 2'd1,
      PM_SLEEP    = 2'd2,
      PM_DISPLAY  = 2'd3
   } pwr_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ARMED = 2'd1,
      ST_COUNT = 2'd2
   } tmr_state_e;

   function automatic logic mode_forces_idle(input logic [1:0] mode);
      return (mode == PM_NORMAL) || (mode == PM_BROWNOUT);
   endfunction

endpackage

// File: rtl/swt_cfg_regs.sv
module swt_cfg_regs #(
   parameter int PRD_W   = 3,
   parameter int PRD_RST = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [PRD_W-1:0] prd_d,
   input  logic             res_d,
   output logic [PRD_W-1:0] prd_q,
   output logic             res_q
);

   initial begin : p_param_chk
      assert (PRD_W >= 1) else $fatal(1, "PRD_W must be at least 1");
      assert (PRD_RST < (1 << PRD_W)) else $fatal(1, "PRD_RST does not fit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prd_q <= PRD_W'(PRD_RST);
         res_q <= 1'b0;
      end else if (wr) begin
         prd_q <= prd_d;
         res_q <= res_d;
      end
   end

endmodule

// File: rtl/swt_arm_ctrl.sv
module swt_arm_ctrl
   import swt_pkg::*;
#(
   parameter int PRD_W     = 3,
   parameter int GUARD_CYC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm_wr,
   input  logic             sleep_cmd,
   input  logic [1:0]       pwr_mode,
   input  logic [PRD_W-1:0] prd_cfg,
   input  logic             res_cfg,
   input  logic             expire,
   output tmr_state_e       state_o,
   output logic             start_o,
   output logic [PRD_W-1:0] lat_prd_o,
   output logic             lat_res_o,
   output logic             late_err_o
);

   localparam int AW = (GUARD_CYC < 1) ? 1 : $clog2(GUARD_CYC + 1);

   initial begin : p_param_chk
      assert (GUARD_CYC >= 0) else $fatal(1, "GUARD_CYC must not be negative");
   end

   tmr_state_e    st_q, st_d;
   logic [AW-1:0] age_q;
   logic          arm_take;
   logic          late_set;
   logic          too_early;

   // guard window check; a zero guard removes the comparator
   generate
      if (GUARD_CYC == 0) begin : g_no_guard
         assign too_early = 1'b0;
      end else begin : g_guard
         assign too_early = (age_q < AW'(GUARD_CYC));
      end
   endgenerate

   always_comb begin
      st_d     = st_q;
      start_o  = 1'b0;
      late_set = 1'b0;
      arm_take = 1'b0;
      if (pwr_mode == PM_BROWNOUT) begin
         st_d = ST_IDLE;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (arm_wr) begin
                  if (sleep_cmd) begin
                     late_set = 1'b1;
                  end else begin
                     st_d     = ST_ARMED;
                     arm_take = 1'b1;
                  end
               end
            end
            ST_ARMED: begin
               if (sleep_cmd) begin
                  if (arm_wr || too_early) begin
                     late_set = 1'b1;
                     st_d     = ST_IDLE;
                  end else begin
                     start_o = 1'b1;
                     st_d    = ST_COUNT;
                  end
               end else if (arm_wr) begin
                  arm_take = 1'b1;
               end
            end
            ST_COUNT: begin
               if (mode_forces_idle(pwr_mode) || expire) begin
                  st_d = ST_IDLE;
               end
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q       <= ST_IDLE;
         age_q      <= '0;
         lat_prd_o  <= '0;
         lat_res_o  <= 1'b0;
         late_err_o <= 1'b0;
      end else begin
         st_q <= st_d;
         if (arm_take) begin
            age_q     <= AW'(1);
            lat_prd_o <= prd_cfg;
            lat_res_o <= res_cfg;
         end else if (age_q < AW'(GUARD_CYC)) begin
            age_q <= age_q + AW'(1);
         end
         if (late_set) begin
            late_err_o <= 1'b1;
         end
      end
   end

   assign state_o = st_q;

endmodule

// File: rtl/swt_countdown.sv
module swt_countdown #(
   parameter int PRD_W      = 3,
   parameter int SHORT_UNIT = 81920,
   parameter int LONG_UNIT  = 1966080
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [PRD_W-1:0] prd,
   input  logic             res,
   input  logic             run,
   output logic             expire
);

   localparam int MAX_UNIT = (LONG_UNIT > SHORT_UNIT) ? LONG_UNIT : SHORT_UNIT;
   localparam int CW       = (MAX_UNIT > 1) ? $clog2(MAX_UNIT) : 1;

   initial begin : p_param_chk
      assert (SHORT_UNIT >= 1) else $fatal(1, "SHORT_UNIT must be at least 1");
      assert (LONG_UNIT >= 1)  else $fatal(1, "LONG_UNIT must be at least 1");
   end

   logic [PRD_W-1:0] pcnt_q;
   logic [CW-1:0]    ucnt_q;
   logic             res_q;
   logic [CW-1:0]    rld_load;
   logic [CW-1:0]    rld_run;

   // one reload constant when both units match, otherwise a select
   generate
      if (SHORT_UNIT == LONG_UNIT) begin : g_one_unit
         assign rld_load = CW'(SHORT_UNIT - 1);
         assign rld_run  = CW'(SHORT_UNIT - 1);
      end else begin : g_two_unit
         assign rld_load = res   ? CW'(LONG_UNIT - 1) : CW'(SHORT_UNIT - 1);
         assign rld_run  = res_q ? CW'(LONG_UNIT - 1) : CW'(SHORT_UNIT - 1);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pcnt_q <= '0;
         ucnt_q <= '0;
         res_q  <= 1'b0;
      end else if (load) begin
         pcnt_q <= prd;
         ucnt_q <= rld_load;
         res_q  <= res;
      end else if (run && (pcnt_q != '0)) begin
         if (ucnt_q == '0) begin
            pcnt_q <= pcnt_q - PRD_W'(1);
            ucnt_q <= rld_run;
         end else begin
            ucnt_q <= ucnt_q - CW'(1);
         end
      end
   end

   assign expire = run && (pcnt_q == '0);

endmodule

// File: rtl/slp_wake_timer.sv
module slp_wake_timer
   import swt_pkg::*;
#(
   parameter int PRD_W      = 3,
   parameter int PRD_RST    = 1,
   parameter int SHORT_UNIT = 81920,
   parameter int LONG_UNIT  = 1966080,
   parameter int GUARD_CYC  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [PRD_W-1:0] cfg_prd_i,
   input  logic             cfg_res_i,
   input  logic             arm_wr,
   input  logic [1:0]       pwr_mode,
   input  logic             sleep_cmd,
   output logic [PRD_W-1:0] cfg_prd_o,
   output logic             cfg_res_o,
   output logic             wake_o,
   output logic             armed_o,
   output logic             late_err_o
);

   tmr_state_e       state;
   logic             start;
   logic [PRD_W-1:0] lat_prd;
   logic             lat_res;
   logic             expire;
   logic             run;
   logic             wake_q;

   swt_cfg_regs #(
      .PRD_W   (PRD_W),
      .PRD_RST (PRD_RST)
   ) cfg_i (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (cfg_wr),
      .prd_d (cfg_prd_i),
      .res_d (cfg_res_i),
      .prd_q (cfg_prd_o),
      .res_q (cfg_res_o)
   );

   swt_arm_ctrl #(
      .PRD_W     (PRD_W),
      .GUARD_CYC (GUARD_CYC)
   ) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm_wr     (arm_wr),
      .sleep_cmd  (sleep_cmd),
      .pwr_mode   (pwr_mode),
      .prd_cfg    (cfg_prd_o),
      .res_cfg    (cfg_res_o),
      .expire     (expire),
      .state_o    (state),
      .start_o    (start),
      .lat_prd_o  (lat_prd),
      .lat_res_o  (lat_res),
      .late_err_o (late_err_o)
   );

   assign run = (state == ST_COUNT) && !mode_forces_idle(pwr_mode);

   swt_countdown #(
      .PRD_W      (PRD_W),
      .SHORT_UNIT (SHORT_UNIT),
      .LONG_UNIT  (LONG_UNIT)
   ) cnt_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (start),
      .prd    (lat_prd),
      .res    (lat_res),
      .run    (run),
      .expire (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wake_q <= 1'b0;
      end else begin
         wake_q <= expire;
      end
   end

   assign wake_o  = wake_q;
   assign armed_o = (state != ST_IDLE);

endmodule

// File: rtl/slp_wake_timer_chk.sv
module slp_wake_timer_chk #(
   parameter int PRD_W = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cfg_wr,
   input logic [1:0]       pwr_mode,
   input logic [PRD_W-1:0] cfg_prd_o,
   input logic             wake_o,
   input logic             armed_o,
   input logic             late_err_o
);

   AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_wr |=> $stable(cfg_prd_o)); // R1

   AST_WAKE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |=> !wake_o); // R4

   AST_WAKE_DISARMED: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> !armed_o); // R4

   AST_WAKE_AFTER_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
      wake_o |-> $past(armed_o)); // R5

   AST_BROWNOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == 2'd1) |=> !armed_o); // R6

   AST_AWAKE_NO_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_mode == 2'd0 || pwr_mode == 2'd1) |=> !wake_o); // R6

   AST_LATE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(late_err_o) |-> !armed_o); // R7

   AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      late_err_o |=> late_err_o); // R8

endmodule

bind slp_wake_timer slp_wake_timer_chk #(.PRD_W(PRD_W)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_wr     (cfg_wr),
   .pwr_mode   (pwr_mode),
   .cfg_prd_o  (cfg_prd_o),
   .wake_o     (wake_o),
   .armed_o    (armed_o),
   .late_err_o (late_err_o)
);

// File: tb/slp_wake_timer_tb_top.sv
module slp_wake_timer_tb_top;

   localparam int SU = 3;
   localparam int LU = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic [2:0] cfg_prd_i = '0;
   logic       cfg_res_i = 1'b0;
   logic       arm_wr = 1'b0;
   logic [1:0] pwr_mode = 2'd0;
   logic       sleep_cmd = 1'b0;
   logic [2:0] cfg_prd_o;
   logic       cfg_res_o;
   logic       wake_o;
   logic       armed_o;
   logic       late_err_o;

   int n_chk = 0;
   int n_bad = 0;
   int cyc   = 0;

   always #2 clk = ~clk;

   slp_wake_timer #(
      .SHORT_UNIT (SU),
      .LONG_UNIT  (LU)
   ) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_wr     (cfg_wr),
      .cfg_prd_i  (cfg_prd_i),
      .cfg_res_i  (cfg_res_i),
      .arm_wr     (arm_wr),
      .pwr_mode   (pwr_mode),
      .sleep_cmd  (sleep_cmd),
      .cfg_prd_o  (cfg_prd_o),
      .cfg_res_o  (cfg_res_o),
      .wake_o     (wake_o),
      .armed_o    (armed_o),
      .late_err_o (late_err_o)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cfg_wr = 0; arm_wr = 0; sleep_cmd = 0; pwr_mode = 2'd0;
      step(); step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic write_cfg(input int prd, input int res);
      cfg_prd_i = 3'(prd); cfg_res_i = 1'(res); cfg_wr = 1'b1;
      step();
      cfg_wr = 1'b0;
   endtask

   // arm, then issue sleep_cmd on the edge that is gap edges after arming
   task automatic arm_sleep(input int gap, input logic [1:0] mode);
      arm_wr = 1'b1;
      if (gap == 0) begin sleep_cmd = 1'b1; pwr_mode = mode; end
      step();
      arm_wr = 1'b0;
      if (gap > 0) begin
         for (int i = 1; i < gap; i++) step();
         sleep_cmd = 1'b1; pwr_mode = mode;
         step();
      end
      sleep_cmd = 1'b0;
   endtask

   // edges until wake after accepting edge; 0 if none within limit
   task automatic wait_wake(input int limit, output int edges);
      edges = 0;
      for (int k = 1; k <= limit; k++) begin
         step();
         if (wake_o) begin edges = k; break; end
      end
   endtask

   task automatic watch_no_wake(input int n, output int seen);
      seen = 0;
      for (int k = 0; k < n; k++) begin
         step();
         if (wake_o) seen = 1;
      end
   endtask

   initial begin : watchdog
      while (cyc < 100000) begin
         @(posedge clk);
         cyc++;
      end
      n_chk++; n_bad++;
      $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin : stim
      int got;
      int seen;
      do_reset();

      // R1 reset values
      check("R1 reset prd", int'(cfg_prd_o), 1);
      check("R1 reset res", int'(cfg_res_o), 0);
      check("R5 reset armed", int'(armed_o), 0);
      check("R8 reset late_err", int'(late_err_o), 0);
      check("R4 reset wake", int'(wake_o), 0);

      // R3 / R10 sweep of every period and both resolutions
      for (int res = 0; res < 2; res++) begin
         for (int prd = 0; prd < 8; prd++) begin
            logic [1:0] md;
            md = (res == 1) ? 2'd3 : 2'd2; // R10 display-only for long unit
            write_cfg(prd, res);
            check("R1 readback prd", int'(cfg_prd_o), prd);
            arm_sleep(3, md);
            check("R5 armed during count", int'(armed_o), 1);
            wait_wake(200, got);
            check($sformatf("R3 interval prd=%0d res=%0d", prd, res), got,
                  prd * (res == 1 ? LU : SU) + 1);
            check("R4 disarmed at wake", int'(armed_o), 0);
            step();
            check("R4 wake single cycle", int'(wake_o), 0);
            pwr_mode = 2'd0;
            step();
         end
      end

      // R9 sleep_cmd mid-countdown is ignored
      write_cfg(3, 0);
      arm_sleep(4, 2'd2);
      got = 0;
      for (int k = 1; k <= 60; k++) begin
         if (k == 3) sleep_cmd = 1'b1;
         step();
         sleep_cmd = 1'b0;
         if (wake_o && got == 0) got = k;
      end
      check("R9 extra sleep_cmd while counting", got, 3 * SU + 1);
      pwr_mode = 2'd0; step();

      // R9 sleep_cmd while disarmed
      sleep_cmd = 1'b1; pwr_mode = 2'd2; step(); sleep_cmd = 1'b0;
      check("R9 idle sleep_cmd armed", int'(armed_o), 0);
      watch_no_wake(30, seen);
      check("R9 idle sleep_cmd wake", seen, 0);
      pwr_mode = 2'd0; step();

      // R2 settings latched at arm
      write_cfg(2, 0);
      arm_wr = 1'b1; step(); arm_wr = 1'b0;
      write_cfg(7, 1);
      step();
      sleep_cmd = 1'b1; pwr_mode = 2'd2; step(); sleep_cmd = 1'b0;
      wait_wake(200, got);
      check("R2 latched interval", got, 2 * SU + 1);
      check("R1 readback after late write", int'(cfg_prd_o), 7);
      pwr_mode = 2'd0; step();

      // R6 normal mode cancels countdown
      write_cfg(7, 1);
      arm_sleep(3, 2'd2);
      for (int k = 0; k < 10; k++) step();
      pwr_mode = 2'd0; step();
      check("R6 normal cancels armed", int'(armed_o), 0);
      pwr_mode = 2'd2;
      watch_no_wake(70, seen);
      check("R6 normal cancel no wake", seen, 0);
      pwr_mode = 2'd0; step();

      // R6 brownout cancels countdown
      write_cfg(1, 0);
      arm_sleep(3, 2'd3);
      step();
      pwr_mode = 2'd1; step();
      check("R6 brownout cancels count", int'(armed_o), 0);
      pwr_mode = 2'd3;
      watch_no_wake(20, seen);
      check("R6 brownout no wake", seen, 0);

      // R6 brownout clears armed timer, arm ignored during brownout
      pwr_mode = 2'd0;
      arm_wr = 1'b1; step(); arm_wr = 1'b0;
      check("R5 armed after arm", int'(armed_o), 1);
      pwr_mode = 2'd1; step();
      check("R6 brownout disarms", int'(armed_o), 0);
      arm_wr = 1'b1; step(); arm_wr = 1'b0;
      check("R6 arm ignored in brownout", int'(armed_o), 0);
      pwr_mode = 2'd0; step();

      // R7 / R8 guard window, every gap from 0 to 3
      for (int g = 0; g < 4; g++) begin
         do_reset();
         arm_sleep(g, 2'd2);
         check($sformatf("R7 late_err gap=%0d", g), int'(late_err_o), (g < 3) ? 1 : 0);
         check($sformatf("R7 armed gap=%0d", g), int'(armed_o), (g < 3) ? 0 : 1);
         if (g < 3) begin
            watch_no_wake(10, seen);
            check("R7 late arm no wake", seen, 0);
            pwr_mode = 2'd0; step();
            write_cfg(0, 0);
            arm_sleep(3, 2'd2);
            wait_wake(20, got);
            check("R8 good sequence after error", got, 1);
            check("R8 late_err still set", int'(late_err_o), 1);
         end else begin
            wait_wake(20, got);
            check("R7 on-time sleep wakes", got, SU + 1);
         end
         pwr_mode = 2'd0; step();
      end

      do_reset();
      check("R8 reset clears late_err", int'(late_err_o), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule